// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This unit sits in the execute stage of a 32-bit processor. It decides whether a trap-word instruction raises a program exception. Each cycle it may receive one instruction, marked by a valid strobe. It compares the first operand against a second operand. The second operand is either another register value or a 16-bit signed immediate widened to the full data width. Each comparison is a signed or unsigned relation, or equality. A 5-bit condition mask picks which of these relations count. If any enabled relation holds, the unit registers a trap request and a trap-cause flag. Both stay high for exactly one clock.

The unit has no back-pressure. It accepts a new instruction on every cycle where the valid strobe is high. Its outputs are plain registered pulses with no ready handshake. A request therefore appears one cycle after the instruction that caused it, and a new instruction in the next cycle is evaluated independently. Decoding the instruction, vectoring the exception and dispatching a handler belong to other blocks.

Top module: `trap_eval_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `trap_req` and `trap_cause` are low after that edge.
- R2: With `use_imm` low, the second operand is `opnd_b`.
- R3: With `use_imm` high, the second operand is `imm` sign-extended to 32 bits (for example, 16'h8000 becomes 32'hFFFF8000), and `opnd_b` has no effect.
- R4: Mask bit `cond_mask[4]` (the most significant bit of the field) enables a trap when `opnd_a` is less than the second operand as signed two's-complement numbers.
- R5: `cond_mask[3]` enables a trap when `opnd_a` is greater than the second operand as signed numbers.
- R6: `cond_mask[2]` enables a trap when `opnd_a` equals the second operand.
- R7: `cond_mask[1]` enables a trap on unsigned less-than, and `cond_mask[0]` enables a trap on unsigned greater-than.
- R8: When several mask bits are set, a trap is raised if any enabled relation holds.
- R9: A mask of 5'b11111 with a valid instruction always traps, whatever the operands are.
- R10: A mask of 5'b00000 never traps.
- R11: When `inst_valid` is low, `trap_req` is low in the following cycle.
- R12: `trap_req` and `trap_cause` rise together in the cycle after a valid instruction whose conditions are met. They fall in the next cycle unless that cycle's instruction also traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | A trap-word instruction is present this cycle |
| use_imm | input | 1 | 1 selects the sign-extended immediate as the second operand |
| cond_mask | input | 5 | Condition enables: [4] signed <, [3] signed >, [2] equal, [1] unsigned <, [0] unsigned > |
| opnd_a | input | 32 | First operand, from a register |
| opnd_b | input | 32 | Second operand in register form |
| imm | input | 16 | Signed immediate for immediate form |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 1 | Marks the request as a trap-type program exception |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 16-bit immediate. These widths make the cases where signed and unsigned order disagree reachable, such as 32'h80000000 against 32'h7FFFFFFF. They also make sign extension of a negative immediate like 16'h8000 or 16'hFFFF observable against large unsigned register values. Back-to-back valid instructions and idle cycles show that each request lasts one clock and belongs only to its own instruction.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int COND_W = 5;

  // Member order matches the condition-mask bit order (first member = MSB).
  typedef struct packed {
    logic s_lt;
    logic s_gt;
    logic eq;
    logic u_lt;
    logic u_gt;
  } cmp_flags_t;
endpackage

// File: rtl/trap_opsel.sv
module trap_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] rhs
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_extend
      assign imm_ext = {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_trunc
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign rhs = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/trap_cmp.sv
module trap_cmp #(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     lhs,
  input  logic [DATA_W-1:0]     rhs,
  output trap_pkg::cmp_flags_t  flags
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] lhs_biased, rhs_biased;

  // Flipping the sign bit turns signed order into unsigned order.
  assign lhs_biased = {~lhs[MSB], lhs[MSB-1:0]};
  assign rhs_biased = {~rhs[MSB], rhs[MSB-1:0]};

  always_comb begin
    flags.u_lt = lhs < rhs;
    flags.u_gt = lhs > rhs;
    flags.s_lt = lhs_biased < rhs_biased;
    flags.s_gt = lhs_biased > rhs_biased;
    flags.eq   = lhs == rhs;
  end

  // R4 R5 R6: exactly one signed relation holds at any time
  a_r4_signed_trichotomy: assert property (@(posedge clk) disable iff (rst)
    $countones({flags.s_lt, flags.s_gt, flags.eq}) == 1);
  // R7: exactly one unsigned relation holds at any time
  a_r7_unsigned_trichotomy: assert property (@(posedge clk) disable iff (rst)
    $countones({flags.u_lt, flags.u_gt, flags.eq}) == 1);
endmodule

// File: rtl/trap_cond.sv
module trap_cond (
  input  trap_pkg::cmp_flags_t              flags,
  input  logic [trap_pkg::COND_W-1:0]       mask,
  output logic                              hit
);
  assign hit = |(flags & mask);
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inst_valid,
  input  logic                        use_imm,
  input  logic [trap_pkg::COND_W-1:0] cond_mask,
  input  logic [DATA_W-1:0]           opnd_a,
  input  logic [DATA_W-1:0]           opnd_b,
  input  logic [IMM_W-1:0]            imm,
  output logic                        trap_req,
  output logic                        trap_cause
);
  localparam int MASK_W = trap_pkg::COND_W;
  localparam logic [MASK_W-1:0] MASK_ALL = '1;

  logic [DATA_W-1:0]    rhs;
  trap_pkg::cmp_flags_t flags;
  logic                 hit;

  trap_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm (use_imm),
    .reg_val (opnd_b),
    .imm_val (imm),
    .rhs     (rhs)
  );

  trap_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .lhs   (opnd_a),
    .rhs   (rhs),
    .flags (flags)
  );

  trap_cond u_cond (
    .flags (flags),
    .mask  (cond_mask),
    .hit   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req   <= 1'b0;
      trap_cause <= 1'b0;
    end else begin
      trap_req   <= inst_valid & hit;
      trap_cause <= inst_valid & hit;
    end
  end

  // R1: reset clears the request
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !trap_req && !trap_cause);
  // R11: no valid instruction means no request next cycle
  a_r11_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !inst_valid |=> !trap_req);
  // R9: a full mask always traps
  a_r9_full_mask: assert property (@(posedge clk) disable iff (rst)
    inst_valid && cond_mask == MASK_ALL |=> trap_req);
  // R10: an empty mask never traps
  a_r10_zero_mask: assert property (@(posedge clk) disable iff (rst)
    cond_mask == '0 |=> !trap_req);
  // R12: a request is always accompanied by its cause flag
  a_r12_cause_with_req: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> trap_cause);
endmodule

// File: tb/sim_trap_eval_unit.sv
module sim_trap_eval_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        inst_valid;
  logic        use_imm;
  logic [4:0]  cond_mask;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        trap_req, trap_cause;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  trap_eval_unit u0 (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .use_imm(use_imm),
    .cond_mask(cond_mask), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  function automatic logic expect_trap(input logic [4:0] m, input logic [31:0] a,
                                       input logic [31:0] b);
    logic r;
    r = 1'b0;
    if (m[4] && ($signed(a) < $signed(b))) r = 1'b1;
    if (m[3] && ($signed(a) > $signed(b))) r = 1'b1;
    if (m[2] && (a == b)) r = 1'b1;
    if (m[1] && ($unsigned(a) < $unsigned(b))) r = 1'b1;
    if (m[0] && ($unsigned(a) > $unsigned(b))) r = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one instruction, then check both outputs one edge later.
  task automatic issue(input string tag, input logic v, input logic ui,
                       input logic [4:0] m, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    logic [31:0] rhs;
    logic exp;
    rhs = ui ? {{16{i[15]}}, i} : b;
    exp = v && expect_trap(m, a, rhs);
    inst_valid = v; use_imm = ui; cond_mask = m;
    opnd_a = a; opnd_b = b; imm = i;
    @(posedge clk);
    @(negedge clk);
    check({tag, " req"}, trap_req, exp);
    check({tag, " cause"}, trap_cause, exp);
  endtask

  task automatic idle();
    inst_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    inst_valid = 1'b1; use_imm = 1'b0; cond_mask = 5'b11111;
    opnd_a = 32'd1; opnd_b = 32'd2; imm = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset req", trap_req, 1'b0);
    check("R1 reset cause", trap_cause, 1'b0);
    rst = 1'b0;
    inst_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reg_form();
    issue("R2 reg slt hit", 1, 0, 5'b10000, 32'hFFFFFFFF, 32'd1, 16'd0);
    issue("R2 reg slt miss", 1, 0, 5'b10000, 32'd5, 32'd5, 16'hFFFF);
  endtask

  task automatic t_imm_form();
    // 16'h8000 -> 32'hFFFF8000; unsigned 32'h7FFFFFFF is below it
    issue("R3 imm ult ext", 1, 1, 5'b00010, 32'h7FFFFFFF, 32'd0, 16'h8000);
    issue("R3 imm eq -1", 1, 1, 5'b00100, 32'hFFFFFFFF, 32'd0, 16'hFFFF);
    issue("R3 imm ignores b", 1, 1, 5'b00100, 32'd7, 32'd9, 16'd7);
    issue("R3 imm sgt neg", 1, 1, 5'b01000, 32'd0, 32'd0, 16'hFFFE);
  endtask

  task automatic t_single_bits();
    issue("R4 slt min", 1, 0, 5'b10000, 32'h80000000, 32'h7FFFFFFF, 16'd0);
    issue("R4 slt miss", 1, 0, 5'b10000, 32'h7FFFFFFF, 32'h80000000, 16'd0);
    issue("R5 sgt hit", 1, 0, 5'b01000, 32'h7FFFFFFF, 32'h80000000, 16'd0);
    issue("R5 sgt eq miss", 1, 0, 5'b01000, 32'd3, 32'd3, 16'd0);
    issue("R6 eq hit", 1, 0, 5'b00100, 32'hDEADBEEF, 32'hDEADBEEF, 16'd0);
    issue("R6 eq miss", 1, 0, 5'b00100, 32'hDEADBEEF, 32'hDEADBEEE, 16'd0);
    issue("R7 ult hit", 1, 0, 5'b00010, 32'h7FFFFFFF, 32'h80000000, 16'd0);
    issue("R7 ult miss", 1, 0, 5'b00010, 32'h80000000, 32'h7FFFFFFF, 16'd0);
    issue("R7 ugt hit", 1, 0, 5'b00001, 32'h80000000, 32'h7FFFFFFF, 16'd0);
    issue("R7 ugt miss", 1, 0, 5'b00001, 32'd4, 32'd4, 16'd0);
  endtask

  task automatic t_multi();
    issue("R8 slt|ugt one holds", 1, 0, 5'b10001, 32'h80000000, 32'd1, 16'd0);
    issue("R8 sgt|ult none", 1, 0, 5'b01010, 32'd9, 32'd9, 16'd0);
    issue("R8 lt|gt on ne", 1, 0, 5'b11000, 32'd1, 32'd2, 16'd0);
  endtask

  task automatic t_full_zero();
    issue("R9 full eq", 1, 0, 5'b11111, 32'd0, 32'd0, 16'd0);
    issue("R9 full imm", 1, 1, 5'b11111, 32'h12345678, 32'd0, 16'h8000);
    issue("R10 zero ne", 1, 0, 5'b00000, 32'h80000000, 32'd1, 16'd0);
    issue("R10 zero eq", 1, 0, 5'b00000, 32'd6, 32'd6, 16'd0);
  endtask

  task automatic t_invalid();
    issue("R11 invalid full", 0, 0, 5'b11111, 32'd1, 32'd2, 16'd0);
    issue("R11 invalid eq", 0, 1, 5'b00100, 32'd3, 32'd0, 16'd3);
  endtask

  task automatic t_pulse();
    // R12: single trap then idle -> one-cycle pulse
    issue("R12 pulse rise", 1, 0, 5'b00100, 32'd8, 32'd8, 16'd0);
    idle();
    check("R12 pulse fall req", trap_req, 1'b0);
    check("R12 pulse fall cause", trap_cause, 1'b0);
    // back-to-back traps keep it high; a miss afterwards drops it
    issue("R12 b2b first", 1, 0, 5'b00010, 32'd1, 32'd2, 16'd0);
    issue("R12 b2b second", 1, 0, 5'b00001, 32'd3, 32'd2, 16'd0);
    issue("R12 b2b miss", 1, 0, 5'b00100, 32'd3, 32'd2, 16'd0);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_reg_form();
    t_imm_form();
    t_single_bits();
    t_multi();
    t_full_zero();
    t_invalid();
    t_pulse();
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule